// File: doc/BRIEF.md
# Interrupt Message Capture Queue

This block watches a stream of incoming memory writes and catches those that are interrupt messages aimed at a programmed address region. Every caught write is stored as one queue entry: the 32-bit data word and the 64-bit target address. Software sees the queue through a small register window. A status bit shows that at least one entry is waiting, and an interrupt line goes high while the queue is non-empty and capture is enabled.

Software removes the head entry by reading its three fields: the data word, the low address word and the high address word. It may read them in any order. The entry leaves the queue only after all three fields have been read once. Reading the same field again does not count a second time. Sixteen vectors are expected. Vector n writes its own number n as data to base + 4·n, inside a 4096-byte region.

Top module: `msi_capture_queue`

## Requirements
- R1: After synchronous reset, every register reads 0, the status reads 0 and `irq_o` is 0.
- R2: The registers at 0x04 (base low), 0x08 (base high), 0x0C (region size) and 0x14 (enable, bit 0 only) read back the value last written. Offsets that are not mapped read 0.
- R3: While enable is 1, a write is captured when its 64-bit address satisfies base ≤ address < base + size. A write outside that range is ignored.
- R4: While enable is 0, no write is captured.
- R5: Status (offset 0x18) bit 0 is 1 while at least one entry is queued.
- R6: The head entry is popped only after data (0x20), address low (0x24) and address high (0x28) have each been read. Any order is accepted. Reading a field a second time does not count again.
- R7: Entries leave the queue in arrival order, and the queue holds 16 entries.
- R8: A write that arrives while the queue is full is dropped and sets status bit 1. That bit stays set until software writes 1 to status bit 1.
- R9: `irq_o` equals status bit 0 ANDed with enable.
- R10: While the queue is empty, the field registers read 0 and reading them does not count toward a later pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid_i | input | 1 | Incoming write present this cycle |
| msg_addr_i | input | 64 | Target address of incoming write |
| msg_data_i | input | 32 | Data word of incoming write |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects occur at the clock edge) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Queue non-empty and capture enabled |

## Verification
The assertions check the following on every cycle. The entry count never exceeds the queue depth. The queue is never written while full and never popped while empty. The pop-tracking flags clear after each pop. A capture grows the count. Nothing is captured while capture is disabled. The overflow bit holds until it is cleared. The interrupt needs enable. Only the bench scenarios can show the rest: that the region bounds are exact at both ends and in the high address word, that entries come out in arrival order with the right fields, that every read order pops exactly once, and that empty-queue reads leave the tracking untouched.

// File: rtl/msi_capture_pkg.sv
// Shared types and register offsets for the interrupt message capture queue.
package msi_capture_pkg;
    typedef struct packed {
        logic [31:0] data;
        logic [63:0] addr;
    } msi_entry_t;

    localparam logic [7:0] OFS_BASE_LO = 8'h04;
    localparam logic [7:0] OFS_BASE_HI = 8'h08;
    localparam logic [7:0] OFS_SIZE    = 8'h0C;
    localparam logic [7:0] OFS_ENABLE  = 8'h14;
    localparam logic [7:0] OFS_STATUS  = 8'h18;
    localparam logic [7:0] OFS_DATA    = 8'h20;
    localparam logic [7:0] OFS_ADDR_LO = 8'h24;
    localparam logic [7:0] OFS_ADDR_HI = 8'h28;

    localparam int NUM_FIELDS = 3;
endpackage

// File: rtl/msi_region_decode.sv
// Region decoder: flags an incoming write whose address lies in
// [base, base + size). Assumes size is a byte count no wider than 32 bits;
// the end bound is formed one bit wider so it cannot wrap.
module msi_region_decode #(
    parameter int AW = 64,
    parameter int SW = 32
) (
    input  logic          valid_i,
    input  logic          enable_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [SW-1:0] size_i,
    output logic          hit_o
);
    logic [AW:0] limit;

    // Exclusive upper bound, one bit wider than the address.
    always_comb limit = {1'b0, base_i} + {{(AW+1-SW){1'b0}}, size_i};

    // Capture decision: enabled, valid, and inside the half-open range.
    always_comb hit_o = valid_i && enable_i && (addr_i >= base_i) && ({1'b0, addr_i} < limit);
endmodule

// File: rtl/msi_entry_fifo.sv
// Circular entry queue with a count. Assumes the caller never pushes
// while full and never pops while empty; the head is shown combinationally.
module msi_entry_fifo
    import msi_capture_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  msi_entry_t push_entry_i,
    input  logic       pop_i,
    output msi_entry_t head_o,
    output logic       full_o,
    output logic       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    msi_entry_t   mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Pointer advance with wrap at the depth.
    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage: written at the write pointer on push.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= push_entry_i;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= next_ptr(wr_ptr);
            if (pop_i)  rd_ptr <= next_ptr(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head and occupancy flags.
    always_comb begin
        empty_o = (count == '0);
        full_o  = (count == DEPTH_C);
        count_o = count;
        head_o  = empty_o ? '0 : mem[rd_ptr];
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= DEPTH_C);
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n) !(push_i && full_o));
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n) !(pop_i && empty_o));
endmodule

// File: rtl/msi_pop_tracker.sv
// Pop sequencer: remembers which head fields have been read and requests
// a pop once every field has been read at least once. Assumes read_hit_i
// is already qualified by a non-empty queue.
module msi_pop_tracker
    import msi_capture_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FIELDS-1:0] read_hit_i,
    output logic                  pop_o
);
    logic [NUM_FIELDS-1:0] seen_q;
    logic [NUM_FIELDS-1:0] seen_next;

    // Per-field merge of past reads and this cycle's read.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        always_comb seen_next[f] = seen_q[f] | read_hit_i[f];
    end

    // A pop fires when the merged set covers every field.
    always_comb pop_o = &seen_next;

    // Flag register: cleared on reset and after each pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_q <= '0;
        else if (pop_o) seen_q <= '0;
        else            seen_q <= seen_next;
    end

    a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n) pop_o |=> (seen_q == '0));
endmodule

// File: rtl/msi_capture_queue.sv
// Interrupt message capture queue top: register window, region decode,
// entry queue and read-triggered pop. Reads are combinational; their side
// effects take place at the clock edge where reg_rd_i is high.
module msi_capture_queue
    import msi_capture_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int REG_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid_i,
    input  logic [63:0]       msg_addr_i,
    input  logic [31:0]       msg_data_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int CW = $clog2(DEPTH+1);

    logic [31:0] base_lo_q, base_hi_q, size_q;
    logic        en_q, ovf_q;
    logic        hit, push, pop, full, empty;
    logic [CW-1:0] count;
    msi_entry_t  head, incoming;
    logic [NUM_FIELDS-1:0] field_rd;
    logic        ovf_clear;

    msi_region_decode #(.AW(64), .SW(32)) u_decode (
        .valid_i  (msg_valid_i),
        .enable_i (en_q),
        .addr_i   (msg_addr_i),
        .base_i   ({base_hi_q, base_lo_q}),
        .size_i   (size_q),
        .hit_o    (hit)
    );

    // Packing of the incoming write and push qualification.
    always_comb begin
        incoming.data = msg_data_i;
        incoming.addr = msg_addr_i;
        push          = hit && !full;
    end

    msi_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .push_entry_i (incoming),
        .pop_i        (pop),
        .head_o       (head),
        .full_o       (full),
        .empty_o      (empty),
        .count_o      (count)
    );

    // Field read strobes, counted only while an entry is present.
    always_comb begin
        field_rd[0] = reg_rd_i && !empty && (reg_addr_i == REG_AW'(OFS_DATA));
        field_rd[1] = reg_rd_i && !empty && (reg_addr_i == REG_AW'(OFS_ADDR_LO));
        field_rd[2] = reg_rd_i && !empty && (reg_addr_i == REG_AW'(OFS_ADDR_HI));
    end

    msi_pop_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_hit_i (field_rd),
        .pop_o      (pop)
    );

    // Write-one-to-clear request for the overflow bit.
    always_comb ovf_clear = reg_wr_i && (reg_addr_i == REG_AW'(OFS_STATUS)) && reg_wdata_i[1];

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            size_q    <= '0;
            en_q      <= 1'b0;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                REG_AW'(OFS_BASE_LO): base_lo_q <= reg_wdata_i;
                REG_AW'(OFS_BASE_HI): base_hi_q <= reg_wdata_i;
                REG_AW'(OFS_SIZE):    size_q    <= reg_wdata_i;
                REG_AW'(OFS_ENABLE):  en_q      <= reg_wdata_i[0];
                default: ;
            endcase
        end
    end

    // Sticky overflow flag: a dropped write wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_q <= 1'b0;
        else if (hit && full)    ovf_q <= 1'b1;
        else if (ovf_clear)      ovf_q <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr_i)
            REG_AW'(OFS_BASE_LO): reg_rdata_o = base_lo_q;
            REG_AW'(OFS_BASE_HI): reg_rdata_o = base_hi_q;
            REG_AW'(OFS_SIZE):    reg_rdata_o = size_q;
            REG_AW'(OFS_ENABLE):  reg_rdata_o = {31'b0, en_q};
            REG_AW'(OFS_STATUS):  reg_rdata_o = {30'b0, ovf_q, !empty};
            REG_AW'(OFS_DATA):    reg_rdata_o = head.data;
            REG_AW'(OFS_ADDR_LO): reg_rdata_o = head.addr[31:0];
            REG_AW'(OFS_ADDR_HI): reg_rdata_o = head.addr[63:32];
            default:              reg_rdata_o = '0;
        endcase
    end

    // Interrupt line.
    always_comb irq_o = !empty && en_q;

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> en_q);
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clear) |=> ovf_q);
    a_r3_capture_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !full && !pop) |=> (count == $past(count) + 1'b1));
    a_r4_no_capture_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (count <= $past(count)));
endmodule

// File: tb/msi_capture_queue_tb.sv
`timescale 1ns/1ps
module msi_capture_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [63:0] msg_addr = '0;
    logic [31:0] msg_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;
    localparam logic [31:0] SIZE = 32'd4096;

    always #2.5 clk = ~clk;

    msi_capture_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .msg_valid_i(msg_valid), .msg_addr_i(msg_addr), .msg_data_i(msg_data),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read with side effect at the following edge.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Read with no side effect (strobe low).
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_data = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    function automatic logic [7:0] field_ofs(input int f);
        return (f == 0) ? 8'h20 : (f == 1) ? 8'h24 : 8'h28;
    endfunction

    // Drain one entry in permutation p (0..5), re-reading the first field.
    task automatic drain(input int p, input logic [63:0] ea, input logic [31:0] ed);
        int ord [3];
        logic [31:0] v;
        logic [31:0] ev [3];
        ev[0] = ed; ev[1] = ea[31:0]; ev[2] = ea[63:32];
        ord[0] = p / 2;
        ord[1] = (ord[0] + 1 + (p % 2)) % 3;
        ord[2] = 3 - ord[0] - ord[1];
        for (int k = 0; k < 3; k++) begin
            rd(field_ofs(ord[k]), v);
            check("R7 field value", v, ev[ord[k]]);
            if (k == 1) begin
                rd(field_ofs(ord[0]), v);
                check("R6 head kept after two fields and reread", v, ev[ord[0]]);
            end
        end
    endtask

    initial begin : watchdog
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(8'h18, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        peek(8'h04, v); check("R1 base lo", v, 0);
        peek(8'h14, v); check("R1 enable", v, 0);
        // R2 configuration readback
        wr(8'h04, BASE[31:0]); wr(8'h08, BASE[63:32]); wr(8'h0C, SIZE);
        peek(8'h04, v); check("R2 base lo", v, BASE[31:0]);
        peek(8'h08, v); check("R2 base hi", v, BASE[63:32]);
        peek(8'h0C, v); check("R2 size", v, SIZE);
        peek(8'h10, v); check("R2 unmapped", v, 0);
        // R4 disabled: in-range write ignored
        send(BASE, 0);
        peek(8'h18, v); check("R4 no capture when disabled", v, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        peek(8'h14, v); check("R2 enable bit only", v, 1);
        // R3 bounds
        send(BASE - 1, 32'hA);
        send(BASE + SIZE, 32'hB);
        send(BASE + 64'h1_0000_0000, 32'hC);
        peek(8'h18, v); check("R3 out of range ignored", v, 0);
        send(BASE, 32'h11);
        send(BASE + SIZE - 1, 32'h22);
        peek(8'h18, v); check("R5 non-empty", v, 1);
        drain(0, BASE, 32'h11);
        drain(5, BASE + SIZE - 1, 32'h22);
        peek(8'h18, v); check("R3 both bounds drained", v, 0);
        // R7 full sweep of 16 vectors, all read orders
        for (int n = 0; n < 16; n++) send(BASE + 4 * n, n);
        peek(8'h18, v); check("R7 sixteen held, no overflow", v, 1);
        check("R9 irq with enable", {31'b0, irq}, 1);
        for (int n = 0; n < 16; n++) drain(n % 6, BASE + 4 * n, n);
        peek(8'h18, v); check("R5 empty after drain", v, 0);
        check("R9 irq low when empty", {31'b0, irq}, 0);
        // R10 empty reads do not count
        rd(8'h20, v); check("R10 data reads 0 when empty", v, 0);
        rd(8'h24, v); check("R10 addr lo reads 0 when empty", v, 0);
        send(BASE + 8, 2);
        rd(8'h24, v); rd(8'h28, v);
        peek(8'h18, v); check("R10 not popped by earlier empty reads", v, 1);
        rd(8'h20, v); check("R10 data", v, 2);
        peek(8'h18, v); check("R6 popped after third field", v, 0);
        // R8 overflow
        for (int n = 0; n < 17; n++) send(BASE + 4 * (n % 16), n);
        peek(8'h18, v); check("R8 overflow flagged", v, 3);
        for (int n = 0; n < 16; n++) drain((n + 3) % 6, BASE + 4 * n, n);
        peek(8'h18, v); check("R8 17th dropped, flag sticky", v, 2);
        wr(8'h18, 32'h1);
        peek(8'h18, v); check("R8 write 1 to bit0 no clear", v, 2);
        wr(8'h18, 32'h2);
        peek(8'h18, v); check("R8 cleared", v, 0);
        // R9 irq gated by enable
        send(BASE + 12, 3);
        wr(8'h14, 0);
        peek(8'h18, v); check("R9 status kept when disabled", v, 1);
        check("R9 irq gated", {31'b0, irq}, 0);
        wr(8'h14, 1);
        check("R9 irq restored", {31'b0, irq}, 1);
        drain(2, BASE + 12, 3);
        peek(8'h18, v); check("R5 final empty", v, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule